// File: doc/BRIEF.md
# Register Transfer and Swap Unit

This unit carries out register-to-register moves for a small CPU register set. The set has two 8-bit accumulators, A and B, and their 16-bit pair D. D has A as its high byte and B as its low byte. It also has three 16-bit registers: X, Y and SP. Each operation takes an opcode, a source selector, a destination selector and the current register contents. One clock later the unit presents one write enable and a new value per physical register (A, B, X, Y, SP). It also presents N, Z and V flag values with a shared flag write enable. Copies between registers of different widths follow fixed rules: a narrow value written into a wide register is zero-filled, and a wide value written into a narrow register is truncated to its low byte. A sign-extending copy and a flag-setting byte copy are provided as separate operations.

The surrounding datapath applies the enables to its register file. The unit holds no register state of its own. It only holds a one-stage registered copy of its result.

Top module: `rxu_xfer_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, every write enable, every value output and every flag output is 0.
- R2: An operation presented with `op_valid` high appears on the outputs after the next rising clock edge. With `op_valid` low, every enable is low after that edge.
- R3: A copy (opcode 0) from an 8-bit register (A=0 or B=1) into a 16-bit register (X=3, Y=4, SP=5) writes the byte with an upper byte of zero.
- R4: A copy (opcode 0) from a 16-bit register or D into A or B writes only the low byte of the source.
- R5: D (selector 2) reads as {A,B}. Writing D asserts both the A and B enables, with A taking the high byte and B the low byte.
- R6: Only opcode 3 asserts `flag_we`. In particular, the plain copy never changes flags. While `flag_we` is low, N, Z and V read 0.
- R7: Opcode 3 copies B into A when `src_sel` is 1, and copies A into B otherwise. `dst_sel` is ignored. N receives bit 7 of the result, Z is 1 when the result is zero, V is 0, and `flag_we` is 1.
- R8: A swap (opcode 1) exchanges two registers. If one side is 8-bit and the other is 16-bit, the 8-bit side receives the low byte and the 16-bit side receives the byte with a zero upper byte.
- R9: When a swap pairs D with A or B, the write to D takes precedence over the byte write on the overlapping half.
- R10: Sign-extend (opcode 2) takes the low byte of the source. A 16-bit destination receives that byte with bit 7 copied into all upper bits. A byte destination receives the byte itself.
- R11: A copy or swap whose source and destination selectors are equal asserts no enable.
- R12: Selectors 6 and 7 read as zero and are never written.
- R13: Every register value output is 0 while its write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 copy, 1 swap, 2 sign-extend, 3 flag-setting byte copy |
| src_sel | input | 3 | Source selector |
| dst_sel | input | 3 | Destination selector |
| a_in | input | 8 | Current A |
| b_in | input | 8 | Current B |
| x_in | input | 16 | Current X |
| y_in | input | 16 | Current Y |
| sp_in | input | 16 | Current SP |
| a_we | output | 1 | Write A |
| a_out | output | 8 | New A |
| b_we | output | 1 | Write B |
| b_out | output | 8 | New B |
| x_we | output | 1 | Write X |
| x_out | output | 16 | New X |
| y_we | output | 1 | Write Y |
| y_out | output | 16 | New Y |
| sp_we | output | 1 | Write SP |
| sp_out | output | 16 | New SP |
| flag_we | output | 1 | Write N, Z and V |
| n_out | output | 1 | New N |
| z_out | output | 1 | New Z |
| v_out | output | 1 | New V |

## Verification
The assertions assume that `op_code`, `src_sel` and `dst_sel` are stable, known values whenever `op_valid` is high. They also assume that the register inputs reflect the register file at that cycle. The bench drives every input only on the falling clock edge and gives each operation exactly one cycle with `op_valid` high. Idle cycles drop `op_valid` and keep the selectors defined. The bench uses selectors 6 and 7 only in the cases that deliberately probe R12.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int OP_W   = 2;

  localparam logic [OP_W-1:0] OP_COPY  = 2'd0;
  localparam logic [OP_W-1:0] OP_SWAP  = 2'd1;
  localparam logic [OP_W-1:0] OP_SEXT  = 2'd2;
  localparam logic [OP_W-1:0] OP_BXFER = 2'd3;

  localparam logic [SEL_W-1:0] SEL_A  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_B  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_D  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_X  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_Y  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_SP = 3'd5;
endpackage

// File: rtl/rxu_src_mux.sv
// Reads one selector as a word: bytes zero-extended, D as {A,B}, unused as 0.
module rxu_src_mux
  import rxu_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int WW = 2 * BW
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [BW-1:0]    a,
  input  logic [BW-1:0]    b,
  input  logic [WW-1:0]    x,
  input  logic [WW-1:0]    y,
  input  logic [WW-1:0]    sp,
  output logic [WW-1:0]    val
);
  always_comb begin
    case (sel)
      SEL_A:   val = {{BW{1'b0}}, a};
      SEL_B:   val = {{BW{1'b0}}, b};
      SEL_D:   val = {a, b};
      SEL_X:   val = x;
      SEL_Y:   val = y;
      SEL_SP:  val = sp;
      default: val = '0;
    endcase
  end
endmodule

// File: rtl/rxu_dst_dec.sv
// Turns one (selector, word) write into per-register enables and values.
module rxu_dst_dec
  import rxu_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NW = 3,
  localparam int WW = 2 * BW
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [WW-1:0]    val,
  output logic             a_we,
  output logic [BW-1:0]    a_v,
  output logic             b_we,
  output logic [BW-1:0]    b_v,
  output logic [NW-1:0]    w_we,
  output logic [WW-1:0]    w_v
);
  always_comb begin
    a_we = 1'b0;
    a_v  = '0;
    b_we = 1'b0;
    b_v  = '0;
    if (en) begin
      case (sel)
        SEL_A: begin a_we = 1'b1; a_v = val[BW-1:0]; end
        SEL_B: begin b_we = 1'b1; b_v = val[BW-1:0]; end
        SEL_D: begin
          a_we = 1'b1; a_v = val[WW-1:BW];
          b_we = 1'b1; b_v = val[BW-1:0];
        end
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_word
    assign w_we[k] = en && (sel == SEL_W'(int'(SEL_X) + k));
  end

  assign w_v = (|w_we) ? val : '0;
endmodule

// File: rtl/rxu_flag_gen.sv
// N/Z/V for the flag-setting byte copy.
module rxu_flag_gen
  import rxu_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          en,
  input  logic [BW-1:0] res,
  output logic          we,
  output logic          n,
  output logic          z,
  output logic          v
);
  assign we = en;
  assign n  = en && res[BW-1];
  assign z  = en && (res == '0);
  assign v  = 1'b0;
endmodule

// File: rtl/rxu_xfer_unit.sv
module rxu_xfer_unit
  import rxu_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int WW = 2 * BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_code,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic [BW-1:0]    a_in,
  input  logic [BW-1:0]    b_in,
  input  logic [WW-1:0]    x_in,
  input  logic [WW-1:0]    y_in,
  input  logic [WW-1:0]    sp_in,
  output logic             a_we,
  output logic [BW-1:0]    a_out,
  output logic             b_we,
  output logic [BW-1:0]    b_out,
  output logic             x_we,
  output logic [WW-1:0]    x_out,
  output logic             y_we,
  output logic [WW-1:0]    y_out,
  output logic             sp_we,
  output logic [WW-1:0]    sp_out,
  output logic             flag_we,
  output logic             n_out,
  output logic             z_out,
  output logic             v_out
);
  localparam int NW = 3;

  logic [WW-1:0] src_val, dst_val;

  rxu_src_mux #(.BW(BW)) u_src (
    .sel(src_sel), .a(a_in), .b(b_in), .x(x_in), .y(y_in), .sp(sp_in), .val(src_val)
  );
  rxu_src_mux #(.BW(BW)) u_dst (
    .sel(dst_sel), .a(a_in), .b(b_in), .x(x_in), .y(y_in), .sp(sp_in), .val(dst_val)
  );

  // Operation decode: a primary write and, for swaps, a secondary write.
  logic             same;
  logic             p_en, s_en, f_en;
  logic [SEL_W-1:0] p_sel, s_sel;
  logic [WW-1:0]    p_val, s_val;
  logic [BW-1:0]    bx_res;

  assign same = (src_sel == dst_sel);

  always_comb begin
    p_en   = 1'b0;
    s_en   = 1'b0;
    f_en   = 1'b0;
    p_sel  = dst_sel;
    s_sel  = src_sel;
    p_val  = src_val;
    s_val  = dst_val;
    bx_res = (src_sel == SEL_B) ? b_in : a_in;
    if (op_valid) begin
      case (op_code)
        OP_COPY: p_en = !same;
        OP_SWAP: begin
          p_en = !same;
          s_en = !same;
        end
        OP_SEXT: begin
          p_en  = 1'b1;
          p_val = {{BW{src_val[BW-1]}}, src_val[BW-1:0]};
        end
        default: begin
          p_en  = 1'b1;
          f_en  = 1'b1;
          p_sel = (src_sel == SEL_B) ? SEL_A : SEL_B;
          p_val = {{BW{1'b0}}, bx_res};
        end
      endcase
    end
  end

  logic             pa_we, pb_we, sa_we, sb_we;
  logic [BW-1:0]    pa_v, pb_v, sa_v, sb_v;
  logic [NW-1:0]    pw_we, sw_we;
  logic [WW-1:0]    pw_v, sw_v;

  rxu_dst_dec #(.BW(BW), .NW(NW)) u_pdec (
    .en(p_en), .sel(p_sel), .val(p_val),
    .a_we(pa_we), .a_v(pa_v), .b_we(pb_we), .b_v(pb_v), .w_we(pw_we), .w_v(pw_v)
  );
  rxu_dst_dec #(.BW(BW), .NW(NW)) u_sdec (
    .en(s_en), .sel(s_sel), .val(s_val),
    .a_we(sa_we), .a_v(sa_v), .b_we(sb_we), .b_v(sb_v), .w_we(sw_we), .w_v(sw_v)
  );

  logic fl_we, fl_n, fl_z, fl_v;

  rxu_flag_gen #(.BW(BW)) u_flag (
    .en(f_en), .res(bx_res), .we(fl_we), .n(fl_n), .z(fl_z), .v(fl_v)
  );

  // Merge: on an overlapping swap the side that names D wins.
  logic          p_is_d;
  logic          a_we_d, b_we_d;
  logic [BW-1:0] a_d, b_d;

  assign p_is_d = (p_sel == SEL_D);

  always_comb begin
    a_we_d = pa_we | sa_we;
    b_we_d = pb_we | sb_we;
    if (pa_we && (!sa_we || p_is_d)) a_d = pa_v;
    else                             a_d = sa_v;
    if (pb_we && (!sb_we || p_is_d)) b_d = pb_v;
    else                             b_d = sb_v;
  end

  logic [NW-1:0] w_we_d, w_we_q;
  logic [WW-1:0] w_d [NW];
  logic [WW-1:0] w_q [NW];

  for (genvar k = 0; k < NW; k++) begin : g_wmerge
    assign w_we_d[k] = pw_we[k] | sw_we[k];
    assign w_d[k]    = pw_we[k] ? pw_v : (sw_we[k] ? sw_v : '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        w_we_q[k] <= 1'b0;
        w_q[k]    <= '0;
      end else begin
        w_we_q[k] <= w_we_d[k];
        w_q[k]    <= w_d[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_we    <= 1'b0;
      a_out   <= '0;
      b_we    <= 1'b0;
      b_out   <= '0;
      flag_we <= 1'b0;
      n_out   <= 1'b0;
      z_out   <= 1'b0;
      v_out   <= 1'b0;
    end else begin
      a_we    <= a_we_d;
      a_out   <= a_d;
      b_we    <= b_we_d;
      b_out   <= b_d;
      flag_we <= fl_we;
      n_out   <= fl_n;
      z_out   <= fl_z;
      v_out   <= fl_v;
    end
  end

  assign x_we   = w_we_q[0];
  assign y_we   = w_we_q[1];
  assign sp_we  = w_we_q[2];
  assign x_out  = w_q[0];
  assign y_out  = w_q[1];
  assign sp_out = w_q[2];
endmodule

// File: rtl/rxu_xfer_unit_chk.sv
module rxu_xfer_unit_chk
  import rxu_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int WW = 2 * BW
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_code,
  input logic [SEL_W-1:0] src_sel,
  input logic [SEL_W-1:0] dst_sel,
  input logic             a_we,
  input logic [BW-1:0]    a_out,
  input logic             b_we,
  input logic [BW-1:0]    b_out,
  input logic             x_we,
  input logic [WW-1:0]    x_out,
  input logic             y_we,
  input logic             sp_we,
  input logic             flag_we,
  input logic             n_out,
  input logic             z_out,
  input logic             v_out
);
  logic any_we;
  assign any_we = a_we | b_we | x_we | y_we | sp_we;

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !any_we && !flag_we);

  a_r6_flags_only_bxfer: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code != OP_BXFER) |=> !flag_we && !n_out && !z_out && !v_out);

  a_r7_v_clear: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> !v_out);

  a_r7_one_byte_target: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> $countones({a_we, b_we, x_we, y_we, sp_we}) == 1 && (a_we || b_we));

  a_r7_z_matches: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> z_out == (a_we ? (a_out == '0) : (b_out == '0)));

  a_r5_d_writes_both: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_COPY && dst_sel == SEL_D && src_sel != SEL_D) |=> a_we && b_we);

  a_r11_self_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_COPY || op_code == OP_SWAP) && src_sel == dst_sel) |=> !any_we);

  a_r12_unused_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_COPY && dst_sel > SEL_SP) |=> !any_we);

  a_r13_a_zero_off: assert property (@(posedge clk) disable iff (rst)
    !a_we |-> a_out == '0);

  a_r13_x_zero_off: assert property (@(posedge clk) disable iff (rst)
    !x_we |-> x_out == '0);
endmodule

bind rxu_xfer_unit rxu_xfer_unit_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .src_sel(src_sel), .dst_sel(dst_sel),
  .a_we(a_we), .a_out(a_out), .b_we(b_we), .b_out(b_out),
  .x_we(x_we), .x_out(x_out), .y_we(y_we), .sp_we(sp_we),
  .flag_we(flag_we), .n_out(n_out), .z_out(z_out), .v_out(v_out)
);

// File: tb/rxu_xfer_unit_test.sv
module rxu_xfer_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        a_we;  logic [7:0]  a;
    logic        b_we;  logic [7:0]  b;
    logic        x_we;  logic [15:0] x;
    logic        y_we;  logic [15:0] y;
    logic        sp_we; logic [15:0] sp;
    logic        f_we;  logic n; logic z; logic v;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic [2:0] src_sel = '0, dst_sel = '0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [15:0] x_in = '0, y_in = '0, sp_in = '0;
  logic a_we, b_we, x_we, y_we, sp_we, flag_we, n_out, z_out, v_out;
  logic [7:0] a_out, b_out;
  logic [15:0] x_out, y_out, sp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxu_xfer_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_sel(src_sel), .dst_sel(dst_sel),
    .a_in(a_in), .b_in(b_in), .x_in(x_in), .y_in(y_in), .sp_in(sp_in),
    .a_we(a_we), .a_out(a_out), .b_we(b_we), .b_out(b_out),
    .x_we(x_we), .x_out(x_out), .y_we(y_we), .y_out(y_out),
    .sp_we(sp_we), .sp_out(sp_out),
    .flag_we(flag_we), .n_out(n_out), .z_out(z_out), .v_out(v_out)
  );

  function automatic exp_t actual();
    return '{a_we, a_out, b_we, b_out, x_we, x_out, y_we, y_out,
             sp_we, sp_out, flag_we, n_out, z_out, v_out};
  endfunction

  function automatic logic [15:0] rd(logic [2:0] s);
    case (s)
      3'd0: return {8'h00, a_in};
      3'd1: return {8'h00, b_in};
      3'd2: return {a_in, b_in};
      3'd3: return x_in;
      3'd4: return y_in;
      3'd5: return sp_in;
      default: return 16'h0;
    endcase
  endfunction

  function automatic void put(inout exp_t e, input logic [2:0] s, input logic [15:0] v);
    case (s)
      3'd0: begin e.a_we = 1; e.a = v[7:0]; end
      3'd1: begin e.b_we = 1; e.b = v[7:0]; end
      3'd2: begin e.a_we = 1; e.a = v[15:8]; e.b_we = 1; e.b = v[7:0]; end
      3'd3: begin e.x_we = 1; e.x = v; end
      3'd4: begin e.y_we = 1; e.y = v; end
      3'd5: begin e.sp_we = 1; e.sp = v; end
      default: ;
    endcase
  endfunction

  function automatic exp_t model();
    exp_t e = '0;
    logic [7:0] r;
    if (!op_valid) return e;
    case (op_code)
      2'd0: if (src_sel != dst_sel) put(e, dst_sel, rd(src_sel));
      2'd1: if (src_sel != dst_sel) begin
        if (dst_sel == 3'd2) begin
          put(e, src_sel, rd(dst_sel)); put(e, dst_sel, rd(src_sel));
        end else begin
          put(e, dst_sel, rd(src_sel)); put(e, src_sel, rd(dst_sel));
        end
      end
      2'd2: begin
        r = rd(src_sel)[7:0];
        put(e, dst_sel, {{8{r[7]}}, r});
      end
      default: begin
        if (src_sel == 3'd1) begin r = b_in; put(e, 3'd0, {8'h00, r}); end
        else                 begin r = a_in; put(e, 3'd1, {8'h00, r}); end
        e.f_we = 1; e.n = r[7]; e.z = (r == 8'h00); e.v = 0;
      end
    endcase
    return e;
  endfunction

  task automatic drive(input logic vld, input logic [1:0] op, input logic [2:0] s,
                       input logic [2:0] d, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] x, input logic [15:0] y, input logic [15:0] sp,
                       input string tag);
    @(negedge clk);
    op_valid = vld; op_code = op; src_sel = s; dst_sel = d;
    a_in = a; b_in = b; x_in = x; y_in = y; sp_in = sp;
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  // Monitor: each rising edge retires the item driven on the previous falling edge.
  always @(posedge clk) begin
    if (!rst) begin
      #1;
      if (exp_q.size() > 0) begin
        exp_t e, got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = actual();
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (actual() !== '0) begin
      errors++;
      $display("FAIL R1: actual=%h expected=%h", actual(), exp_t'(0));
    end
    @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (actual() !== '0) begin
      errors++;
      $display("FAIL R1: actual=%h expected=%h", actual(), exp_t'(0));
    end

    drive(1, 2'd0, 3'd0, 3'd3, 8'h9C, 8'h11, 16'hAAAA, 16'h0, 16'h0, "R3 copy A->X");
    drive(1, 2'd0, 3'd1, 3'd5, 8'h00, 8'hF0, 16'h0, 16'h0, 16'h1234, "R3 copy B->SP");
    drive(1, 2'd0, 3'd4, 3'd1, 8'h00, 8'h00, 16'h0, 16'hBEEF, 16'h0, "R4 copy Y->B");
    drive(1, 2'd0, 3'd2, 3'd0, 8'hAB, 8'hCD, 16'h0, 16'h0, 16'h0, "R4 copy D->A");
    drive(1, 2'd0, 3'd3, 3'd2, 8'h00, 8'h00, 16'h1234, 16'h0, 16'h0, "R5 copy X->D");
    drive(1, 2'd0, 3'd2, 3'd4, 8'hAB, 8'hCD, 16'h0, 16'h0, 16'h0, "R5 copy D->Y");
    drive(1, 2'd0, 3'd0, 3'd1, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0, "R6 plain copy no flags");
    drive(1, 2'd3, 3'd1, 3'd3, 8'h00, 8'h80, 16'h0, 16'h0, 16'h0, "R7 B->A negative");
    drive(1, 2'd3, 3'd0, 3'd5, 8'h00, 8'h77, 16'h0, 16'h0, 16'h0, "R7 A->B zero");
    drive(1, 2'd3, 3'd4, 3'd1, 8'h42, 8'h00, 16'h0, 16'h0, 16'h0, "R7 A->B positive");
    drive(1, 2'd1, 3'd0, 3'd3, 8'h55, 8'h00, 16'h1234, 16'h0, 16'h0, "R8 swap A,X");
    drive(1, 2'd1, 3'd5, 3'd1, 8'h00, 8'hC3, 16'h0, 16'h0, 16'h9876, "R8 swap SP,B");
    drive(1, 2'd1, 3'd3, 3'd4, 8'h00, 8'h00, 16'h1111, 16'h2222, 16'h0, "R8 swap X,Y");
    drive(1, 2'd1, 3'd0, 3'd1, 8'h12, 8'h34, 16'h0, 16'h0, 16'h0, "R8 swap A,B");
    drive(1, 2'd1, 3'd0, 3'd2, 8'h12, 8'h34, 16'h0, 16'h0, 16'h0, "R9 swap A,D");
    drive(1, 2'd1, 3'd2, 3'd1, 8'h12, 8'h34, 16'h0, 16'h0, 16'h0, "R9 swap D,B");
    drive(1, 2'd2, 3'd0, 3'd3, 8'h85, 8'h00, 16'h0, 16'h0, 16'h0, "R10 sext A->X");
    drive(1, 2'd2, 3'd1, 3'd4, 8'h00, 8'h7F, 16'h0, 16'h0, 16'h0, "R10 sext B->Y");
    drive(1, 2'd2, 3'd3, 3'd1, 8'h00, 8'h00, 16'h12F0, 16'h0, 16'h0, "R10 sext X->B");
    drive(1, 2'd2, 3'd0, 3'd2, 8'hC0, 8'h00, 16'h0, 16'h0, 16'h0, "R10 sext A->D");
    drive(1, 2'd0, 3'd3, 3'd3, 8'h00, 8'h00, 16'h5A5A, 16'h0, 16'h0, "R11 copy X->X");
    drive(1, 2'd1, 3'd2, 3'd2, 8'h01, 8'h02, 16'h0, 16'h0, 16'h0, "R11 swap D,D");
    drive(1, 2'd0, 3'd6, 3'd3, 8'hFF, 8'hFF, 16'hFFFF, 16'h0, 16'h0, "R12 copy sel6->X");
    drive(1, 2'd0, 3'd0, 3'd7, 8'hFF, 8'h00, 16'h0, 16'h0, 16'h0, "R12 copy A->sel7");
    drive(0, 2'd0, 3'd0, 3'd3, 8'hFF, 8'h00, 16'h0, 16'h0, 16'h0, "R2 idle");
    drive(1, 2'd3, 3'd1, 3'd0, 8'h00, 8'h01, 16'h0, 16'h0, 16'h0, "R2 back-to-back");
    drive(0, 2'd0, 3'd0, 3'd0, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, "R13 idle zeros");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule